// File: doc/BRIEF.md
# Limited-Pointer Directory Entry

This block keeps the coherence directory record for one memory line. While the line has only a few readers, the record lists each sharing node by number in a short pointer array. When one more distinct reader arrives than the array can hold, the record changes to a bit vector. In that form, each bit stands either for one node (exact form) or for a group of `GRP` neighbouring nodes (coarse form). A line held for writing keeps a single pointer to the owning processor. Each node contains two processors, so the owner's node number is the processor number shifted right by one.

The surrounding protocol engine sends one command per cycle: add a reader, make a processor the owner, wipe the record, or ask for the list of nodes to invalidate on behalf of a writing node. For an invalidation request the block walks its record. It presents one target node per cycle, lowest number first, and never names the writer's own node. It then raises a done strobe together with the total, so the requester knows how many acknowledgements to wait for. The `coarse_sel` input is sampled when the pointer array overflows. A run-time policy drives it high when readers may be spread over the whole machine and low when they stay within a region small enough for exact per-node bits.

Top module: `dir_ptr_entry`

## Requirements
- R1: After reset the record is in pointer form (`fmt` = 0) with `ptr_used` = 0, `busy` = 0, `inv_valid` = 0, `inv_done` = 0 and `inv_count` = 0.
- R2: Command ADD (`cmd` = 1) in pointer form with a node not yet listed and a free pointer stores that node and increments `ptr_used`. An ADD of a node already listed leaves the record unchanged.
- R3: An ADD of an unlisted node while all `PTRS` pointers are in use switches the record, at the same clock edge, to coarse form (`fmt` = 2) if `coarse_sel` = 1 or to exact form (`fmt` = 1) if `coarse_sel` = 0. All previous pointers plus the new node stay marked, and `ptr_used` becomes 0. A later ADD in either vector form marks the node's bit (exact) or its group bit (coarse).
- R4: In coarse form the invalidation list holds every node n whose group n/`GRP` is marked, including nodes that never read the line.
- R5: Command OWN (`cmd` = 2) puts the record in owner form (`fmt` = 3) with `own_proc` = `cmd_proc`. The invalidation list is then the owner's node, `own_proc` >> 1, which covers both of its processors.
- R6: Command CLEAR (`cmd` = 3) returns the record to empty pointer form (`fmt` = 0, `ptr_used` = 0, `own_proc` = 0). A later invalidation request then yields no targets.
- R7: Command INVAL (`cmd` = 4, writer in `cmd_node`) raises `busy` at the next edge. Targets are then presented on `inv_node` with `inv_valid` high in consecutive cycles and strictly ascending node order, and the writer's node never appears.
- R8: `inv_done` is high for exactly one cycle, in the cycle after the last target (or in the first busy cycle if there are none). At that point `inv_count` equals the number of targets presented, and `inv_count` holds that value until the next request.
- R9: Any command arriving while `busy` is high is ignored: the record (`fmt`, `ptr_used`, `own_proc`) and the list being emitted are unchanged.
- R10: An ADD in owner form changes the record to pointer form holding the owner's node followed by the added node (a single pointer if they are the same node).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd | input | 3 | 0 none, 1 ADD, 2 OWN, 3 CLEAR, 4 INVAL |
| cmd_node | input | NW | Node for ADD, or the writer's node for INVAL |
| cmd_proc | input | NW+1 | Processor for OWN |
| coarse_sel | input | 1 | Spill into coarse (1) or exact (0) vector on overflow |
| busy | output | 1 | Invalidation walk in progress; commands ignored |
| fmt | output | 2 | Record form: 0 pointer, 1 exact, 2 coarse, 3 owner |
| ptr_used | output | PCW | Pointers in use (pointer form only, otherwise 0) |
| own_proc | output | NW+1 | Owning processor |
| inv_valid | output | 1 | `inv_node` holds an invalidation target |
| inv_node | output | NW | Node to invalidate |
| inv_done | output | 1 | One-cycle end-of-list strobe |
| inv_count | output | CW | Number of targets in the last list |

## Verification
Several properties are checked on every cycle. Each list must be strictly ascending and must not name the latched writer. The done strobe must be a single cycle, and its total must match a count of valid cycles. The record must stay frozen while busy, a jump from pointer form to a vector form is legal only from a full array, and CLEAR must produce an empty record. Only the bench's scenarios can show the contents of each list. This covers group expansion in coarse form, the owner's node in owner form, the pointer order after a downgrade from owner form, and ignored commands. They are compared cycle by cycle against a queue-based model during directed and random command streams.

// File: rtl/dir_ptr_pkg.sv
package dir_ptr_pkg;
  typedef enum logic [2:0] {
    CMD_NOP   = 3'd0,
    CMD_ADD   = 3'd1,
    CMD_OWN   = 3'd2,
    CMD_CLEAR = 3'd3,
    CMD_INVAL = 3'd4
  } dir_cmd_e;

  typedef enum logic [1:0] {
    FMT_PTR    = 2'd0,
    FMT_EXACT  = 2'd1,
    FMT_COARSE = 2'd2,
    FMT_OWN    = 2'd3
  } dir_fmt_e;
endpackage

// File: rtl/dir_entry_state.sv
module dir_entry_state
  import dir_ptr_pkg::*;
#(
  parameter int NODES = 16,
  parameter int PTRS  = 4,
  parameter int GRP   = 4,
  localparam int NW   = $clog2(NODES),
  localparam int PW   = NW + 1,
  localparam int PCW  = $clog2(PTRS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                accept,
  input  logic [2:0]          cmd,
  input  logic [NW-1:0]       node,
  input  logic [PW-1:0]       proc,
  input  logic                coarse_sel,
  output logic [1:0]          fmt,
  output logic [PCW-1:0]      used,
  output logic [PTRS*NW-1:0]  ptr_flat,
  output logic [NODES-1:0]    vec,
  output logic [PW-1:0]       own,
  output logic                ev_overflow,
  output logic                ev_dup
);
  logic [1:0]       fmt_q, fmt_d;
  logic [PCW-1:0]   used_q, used_d;
  logic [NW-1:0]    ptr_q [PTRS];
  logic [NW-1:0]    ptr_d [PTRS];
  logic [NODES-1:0] vec_q, vec_d, spill;
  logic [PW-1:0]    own_q, own_d;
  logic [NW-1:0]    own_node;

  // Bit that marks a node: itself in exact form, its group in coarse form.
  function automatic logic [NW-1:0] slot(input logic [NW-1:0] id, input logic coarse);
    return coarse ? NW'(id / GRP) : id;
  endfunction

  assign own_node = own_q[PW-1:1];

  always_comb begin
    ev_dup = 1'b0;
    for (int i = 0; i < PTRS; i++)
      if (PCW'(i) < used_q && ptr_q[i] == node) ev_dup = 1'b1;
  end

  assign ev_overflow = accept && (cmd == CMD_ADD) && (fmt_q == FMT_PTR) &&
                       !ev_dup && (used_q == PCW'(PTRS));

  always_comb begin
    spill = '0;
    for (int i = 0; i < PTRS; i++) spill[slot(ptr_q[i], coarse_sel)] = 1'b1;
    spill[slot(node, coarse_sel)] = 1'b1;
  end

  always_comb begin
    fmt_d  = fmt_q;
    used_d = used_q;
    vec_d  = vec_q;
    own_d  = own_q;
    for (int i = 0; i < PTRS; i++) ptr_d[i] = ptr_q[i];
    if (accept) begin
      case (cmd)
        CMD_ADD: begin
          case (fmt_q)
            FMT_PTR: begin
              if (ev_overflow) begin
                fmt_d  = coarse_sel ? FMT_COARSE : FMT_EXACT;
                vec_d  = spill;
                used_d = '0;
              end else if (!ev_dup) begin
                for (int i = 0; i < PTRS; i++)
                  if (PCW'(i) == used_q) ptr_d[i] = node;
                used_d = used_q + PCW'(1);
              end
            end
            FMT_EXACT:  vec_d[node] = 1'b1;
            FMT_COARSE: vec_d[slot(node, 1'b1)] = 1'b1;
            default: begin
              fmt_d    = FMT_PTR;
              ptr_d[0] = own_node;
              if (node == own_node) begin
                used_d = PCW'(1);
              end else begin
                ptr_d[1] = node;
                used_d   = PCW'(2);
              end
            end
          endcase
        end
        CMD_OWN: begin
          fmt_d  = FMT_OWN;
          own_d  = proc;
          used_d = '0;
          vec_d  = '0;
        end
        CMD_CLEAR: begin
          fmt_d  = FMT_PTR;
          own_d  = '0;
          used_d = '0;
          vec_d  = '0;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fmt_q  <= FMT_PTR;
      used_q <= '0;
      vec_q  <= '0;
      own_q  <= '0;
      for (int i = 0; i < PTRS; i++) ptr_q[i] <= '0;
    end else begin
      fmt_q  <= fmt_d;
      used_q <= used_d;
      vec_q  <= vec_d;
      own_q  <= own_d;
      for (int i = 0; i < PTRS; i++) ptr_q[i] <= ptr_d[i];
    end
  end

  for (genvar g = 0; g < PTRS; g++) begin : g_flat
    assign ptr_flat[g*NW +: NW] = ptr_q[g];
  end

  assign fmt  = fmt_q;
  assign used = used_q;
  assign vec  = vec_q;
  assign own  = own_q;
endmodule

// File: rtl/dir_inval_walker.sv
module dir_inval_walker
  import dir_ptr_pkg::*;
#(
  parameter int NODES = 16,
  parameter int PTRS  = 4,
  parameter int GRP   = 4,
  localparam int NW   = $clog2(NODES),
  localparam int PCW  = $clog2(PTRS + 1),
  localparam int CW   = $clog2(NODES + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [NW-1:0]      writer,
  input  logic [1:0]         fmt,
  input  logic [PCW-1:0]     used,
  input  logic [PTRS*NW-1:0] ptr_flat,
  input  logic [NODES-1:0]   vec,
  input  logic [NW-1:0]      own_node,
  output logic               busy,
  output logic               inv_valid,
  output logic [NW-1:0]      inv_node,
  output logic               inv_done,
  output logic [CW-1:0]      inv_count
);
  logic [NODES-1:0] pend_q;
  logic             walk_q;
  logic [CW-1:0]    cnt_q;

  // Expand the record into one bit per node that must be invalidated.
  function automatic logic [NODES-1:0] targets(
    input logic [1:0] f, input logic [PCW-1:0] u, input logic [PTRS*NW-1:0] pf,
    input logic [NODES-1:0] v, input logic [NW-1:0] on, input logic [NW-1:0] wr);
    logic [NODES-1:0] m;
    m = '0;
    case (f)
      FMT_PTR: for (int i = 0; i < PTRS; i++)
                 if (PCW'(i) < u) m[pf[i*NW +: NW]] = 1'b1;
      FMT_EXACT: m = v;
      FMT_COARSE: for (int n = 0; n < NODES; n++)
                    m[NW'(n)] = v[NW'(n / GRP)];
      default: m[on] = 1'b1;
    endcase
    m[wr] = 1'b0;
    return m;
  endfunction

  function automatic logic [NW-1:0] lowest(input logic [NODES-1:0] m);
    logic [NW-1:0] r;
    r = '0;
    for (int n = NODES - 1; n >= 0; n--)
      if (m[NW'(n)]) r = NW'(n);
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      walk_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start) begin
      pend_q <= targets(fmt, used, ptr_flat, vec, own_node, writer);
      walk_q <= 1'b1;
      cnt_q  <= '0;
    end else if (walk_q) begin
      if (|pend_q) begin
        pend_q[lowest(pend_q)] <= 1'b0;
        cnt_q <= cnt_q + CW'(1);
      end else begin
        walk_q <= 1'b0;
      end
    end
  end

  assign busy      = walk_q;
  assign inv_valid = walk_q && (|pend_q);
  assign inv_done  = walk_q && !(|pend_q);
  assign inv_node  = lowest(pend_q);
  assign inv_count = cnt_q;
endmodule

// File: rtl/dir_ptr_entry.sv
module dir_ptr_entry
  import dir_ptr_pkg::*;
#(
  parameter int NODES = 16,
  parameter int PTRS  = 4,
  parameter int GRP   = 4,
  localparam int NW   = $clog2(NODES),
  localparam int PW   = NW + 1,
  localparam int PCW  = $clog2(PTRS + 1),
  localparam int CW   = $clog2(NODES + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [2:0]     cmd,
  input  logic [NW-1:0]  cmd_node,
  input  logic [PW-1:0]  cmd_proc,
  input  logic           coarse_sel,
  output logic           busy,
  output logic [1:0]     fmt,
  output logic [PCW-1:0] ptr_used,
  output logic [PW-1:0]  own_proc,
  output logic           inv_valid,
  output logic [NW-1:0]  inv_node,
  output logic           inv_done,
  output logic [CW-1:0]  inv_count
);
  logic               accept;
  logic               start_walk;
  logic [PTRS*NW-1:0] ptr_flat;
  logic [NODES-1:0]   vec;
  logic               ev_overflow;
  logic               ev_dup;

  assign accept     = (cmd != CMD_NOP) && !busy;
  assign start_walk = accept && (cmd == CMD_INVAL);

  dir_entry_state #(.NODES(NODES), .PTRS(PTRS), .GRP(GRP)) u_state (
    .clk(clk), .rst_n(rst_n), .accept(accept), .cmd(cmd), .node(cmd_node),
    .proc(cmd_proc), .coarse_sel(coarse_sel), .fmt(fmt), .used(ptr_used),
    .ptr_flat(ptr_flat), .vec(vec), .own(own_proc),
    .ev_overflow(ev_overflow), .ev_dup(ev_dup)
  );

  dir_inval_walker #(.NODES(NODES), .PTRS(PTRS), .GRP(GRP)) u_walk (
    .clk(clk), .rst_n(rst_n), .start(start_walk), .writer(cmd_node),
    .fmt(fmt), .used(ptr_used), .ptr_flat(ptr_flat), .vec(vec),
    .own_node(own_proc[PW-1:1]), .busy(busy), .inv_valid(inv_valid),
    .inv_node(inv_node), .inv_done(inv_done), .inv_count(inv_count)
  );
endmodule

// File: rtl/dir_ptr_entry_chk.sv
module dir_ptr_entry_chk #(
  parameter int NODES = 16,
  parameter int PTRS  = 4,
  localparam int NW   = $clog2(NODES),
  localparam int PCW  = $clog2(PTRS + 1),
  localparam int CW   = $clog2(NODES + 1)
) (
  input logic           clk,
  input logic           rst_n,
  input logic [2:0]     cmd,
  input logic [NW-1:0]  cmd_node,
  input logic           busy,
  input logic [1:0]     fmt,
  input logic [PCW-1:0] ptr_used,
  input logic           inv_valid,
  input logic [NW-1:0]  inv_node,
  input logic           inv_done,
  input logic [CW-1:0]  inv_count,
  input logic           ev_overflow
);
  logic [NW-1:0] wr_q;
  logic [CW-1:0] seen_q;
  logic          take_inval;

  assign take_inval = (cmd == 3'd4) && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q   <= '0;
      seen_q <= '0;
    end else if (take_inval) begin
      wr_q   <= cmd_node;
      seen_q <= '0;
    end else if (inv_valid) begin
      seen_q <= seen_q + CW'(1);
    end
  end

  a_r1_ptr_bound: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_used <= PCW'(PTRS));

  a_r3_spill_only_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    ((fmt == 2'd1 || fmt == 2'd2) && $past(fmt) == 2'd0) |-> $past(ptr_used) == PCW'(PTRS));

  a_r3_overflow_event: assert property (@(posedge clk) disable iff (!rst_n)
    ev_overflow |=> (fmt == 2'd1 || fmt == 2'd2) && ptr_used == '0);

  a_r6_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 3'd3 && !busy) |=> (fmt == 2'd0 && ptr_used == '0));

  a_r7_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_valid && $past(inv_valid)) |-> inv_node > $past(inv_node));

  a_r7_skip_writer: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |-> inv_node != wr_q);

  a_r7_valid_in_walk: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_valid || inv_done) |-> busy);

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    inv_done |=> !inv_done);

  a_r8_count_matches: assert property (@(posedge clk) disable iff (!rst_n)
    inv_done |-> inv_count == seen_q);

  a_r9_frozen_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(fmt) && $stable(ptr_used)));
endmodule

bind dir_ptr_entry dir_ptr_entry_chk #(.NODES(NODES), .PTRS(PTRS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd(cmd), .cmd_node(cmd_node), .busy(busy),
  .fmt(fmt), .ptr_used(ptr_used), .inv_valid(inv_valid), .inv_node(inv_node),
  .inv_done(inv_done), .inv_count(inv_count), .ev_overflow(ev_overflow)
);

// File: tb/tb_dir_ptr_entry.sv
module tb_dir_ptr_entry;
  localparam int NODES = 16;
  localparam int PTRS  = 4;
  localparam int GRP   = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] cmd = '0;
  logic [3:0] cmd_node = '0;
  logic [4:0] cmd_proc = '0;
  logic       coarse_sel = 1'b0;
  logic       busy, inv_valid, inv_done;
  logic [1:0] fmt;
  logic [2:0] ptr_used;
  logic [4:0] own_proc, inv_count;
  logic [3:0] inv_node;

  int vectors = 0;
  int miscompares = 0;
  int got[$];

  // behavioural reference state
  int m_fmt, m_own, m_cnt;
  int m_ptr[$];
  int m_list[$];
  bit [15:0] m_vec;
  bit m_busy;

  always #5 clk = ~clk;

  dir_ptr_entry #(.NODES(NODES), .PTRS(PTRS), .GRP(GRP)) dut (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .cmd_node(cmd_node), .cmd_proc(cmd_proc),
    .coarse_sel(coarse_sel), .busy(busy), .fmt(fmt), .ptr_used(ptr_used),
    .own_proc(own_proc), .inv_valid(inv_valid), .inv_node(inv_node),
    .inv_done(inv_done), .inv_count(inv_count)
  );

  function automatic bit listed(int n);
    foreach (m_ptr[i]) if (m_ptr[i] == n) return 1'b1;
    return 1'b0;
  endfunction

  function automatic bit hit(int n);
    case (m_fmt)
      0: return listed(n);
      1: return m_vec[n];
      2: return m_vec[n / GRP];
      default: return n == (m_own >> 1);
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_fmt = 0; m_own = 0; m_cnt = 0; m_vec = '0; m_busy = 0;
      m_ptr.delete(); m_list.delete();
    end else if (m_busy) begin
      if (m_list.size() > 0) begin
        void'(m_list.pop_front());
        m_cnt++;
      end else m_busy = 0;
    end else begin
      case (cmd)
        3'd1: begin
          if (m_fmt == 0) begin
            if (!listed(cmd_node)) begin
              if (m_ptr.size() < PTRS) m_ptr.push_back(cmd_node);
              else begin
                m_vec = '0;
                foreach (m_ptr[i]) m_vec[coarse_sel ? m_ptr[i] / GRP : m_ptr[i]] = 1'b1;
                m_vec[coarse_sel ? cmd_node / GRP : cmd_node] = 1'b1;
                m_fmt = coarse_sel ? 2 : 1;
                m_ptr.delete();
              end
            end
          end else if (m_fmt == 1) m_vec[cmd_node] = 1'b1;
          else if (m_fmt == 2) m_vec[cmd_node / GRP] = 1'b1;
          else begin
            m_fmt = 0;
            m_ptr.delete();
            m_ptr.push_back(m_own >> 1);
            if (int'(cmd_node) != (m_own >> 1)) m_ptr.push_back(cmd_node);
          end
        end
        3'd2: begin m_fmt = 3; m_own = cmd_proc; m_ptr.delete(); m_vec = '0; end
        3'd3: begin m_fmt = 0; m_own = 0; m_ptr.delete(); m_vec = '0; end
        3'd4: begin
          m_list.delete();
          for (int n = 0; n < NODES; n++)
            if (hit(n) && n != int'(cmd_node)) m_list.push_back(n);
          m_busy = 1; m_cnt = 0;
        end
        default: ;
      endcase
    end
  end

  task automatic check(bit ok, string tag, int act, int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison against the reference
  always @(negedge clk) begin
    if (rst_n) begin
      check(int'(fmt) == m_fmt, "R3 fmt", fmt, m_fmt);
      check(int'(ptr_used) == m_ptr.size(), "R2 ptr_used", ptr_used, m_ptr.size());
      check(int'(own_proc) == m_own, "R5 own_proc", own_proc, m_own);
      check(busy == m_busy, "R9 busy", busy, m_busy);
      check(inv_valid == (m_busy && m_list.size() > 0), "R7 inv_valid", inv_valid,
            m_busy && m_list.size() > 0);
      if (m_busy && m_list.size() > 0)
        check(int'(inv_node) == m_list[0], "R7 inv_node", inv_node, m_list[0]);
      check(inv_done == (m_busy && m_list.size() == 0), "R8 inv_done", inv_done,
            m_busy && m_list.size() == 0);
      check(int'(inv_count) == m_cnt, "R8 inv_count", inv_count, m_cnt);
      if (inv_valid) got.push_back(int'(inv_node));
    end
  end

  task automatic issue(int c, int node, int proc, bit cs);
    @(negedge clk);
    cmd = 3'(c); cmd_node = 4'(node); cmd_proc = 5'(proc); coarse_sel = cs;
    @(negedge clk);
    cmd = '0;
  endtask

  task automatic run_inv(int writer);
    got.delete();
    issue(4, writer, 0, 1'b0);
    while (busy) @(negedge clk);
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(fmt == 2'd0 && ptr_used == 3'd0, "R1 reset form", fmt, 0);
    check(!busy && !inv_valid && !inv_done && inv_count == 0, "R1 reset walk", busy, 0);
    rst_n = 1'b1;

    // R2 add and duplicate
    issue(1, 3, 0, 0); issue(1, 7, 0, 0); issue(1, 3, 0, 0);
    check(ptr_used == 3'd2, "R2 duplicate ignored", ptr_used, 2);

    // R3 coarse spill, R4 group expansion
    issue(1, 1, 0, 0); issue(1, 12, 0, 0);
    check(ptr_used == 3'd4, "R2 fill", ptr_used, 4);
    issue(1, 13, 0, 1);
    check(fmt == 2'd2 && ptr_used == 0, "R3 coarse spill", fmt, 2);
    run_inv(5);
    check(got.size() == 11, "R4 coarse list size", got.size(), 11);
    check(got.size() == 11 && got[0] == 0 && got[10] == 15, "R4 coarse ends",
          got.size() > 0 ? got[0] : -1, 0);
    check(inv_count == 5'd11, "R8 count", inv_count, 11);

    // R6 clear
    issue(3, 0, 0, 0);
    check(fmt == 2'd0 && ptr_used == 0, "R6 cleared", fmt, 0);
    run_inv(0);
    check(got.size() == 0 && inv_count == 0, "R6 empty list", inv_count, 0);

    // R3 exact spill, R7 writer skipped
    issue(1, 0, 0, 0); issue(1, 1, 0, 0); issue(1, 2, 0, 0); issue(1, 3, 0, 0);
    issue(1, 9, 0, 0);
    check(fmt == 2'd1, "R3 exact spill", fmt, 1);
    run_inv(9);
    check(got.size() == 4 && got[3] == 3, "R7 writer skipped", got.size(), 4);

    // R5 owner form
    issue(2, 0, 11, 0);
    check(fmt == 2'd3 && own_proc == 5'd11, "R5 owner", own_proc, 11);
    run_inv(0);
    check(got.size() == 1 && got[0] == 5, "R5 owner node", got.size() > 0 ? got[0] : -1, 5);
    run_inv(5);
    check(got.size() == 0 && inv_count == 0, "R8 empty done", inv_count, 0);

    // R10 downgrade on add
    issue(1, 7, 0, 0);
    check(fmt == 2'd0 && ptr_used == 3'd2, "R10 downgrade", ptr_used, 2);
    run_inv(15);
    check(got.size() == 2 && got[0] == 5 && got[1] == 7, "R10 list", got.size(), 2);

    // R9 command during walk ignored
    got.delete();
    issue(4, 15, 0, 0);
    issue(3, 0, 0, 0);
    while (busy) @(negedge clk);
    check(fmt == 2'd0 && ptr_used == 3'd2, "R9 clear ignored", ptr_used, 2);
    check(got.size() == 2, "R9 list intact", got.size(), 2);

    // random stream against the reference
    for (int k = 0; k < 600; k++) begin
      @(negedge clk);
      cmd = 3'($urandom_range(0, 4));
      cmd_node = 4'($urandom_range(0, 15));
      cmd_proc = 5'($urandom_range(0, 31));
      coarse_sel = 1'($urandom_range(0, 1));
    end
    @(negedge clk);
    cmd = '0;
    repeat (20) @(negedge clk);
    report();
  end
endmodule